// File: doc/BRIEF.md
# Clocked Serial Port with Read-Triggered Receive

This block is an 8-bit synchronous serial port that sits on a simple register bus. It has two registers. One is a shift register that turns a parallel byte into a serial bit stream and collects incoming serial bits back into a byte. The other is a control register that enables the port, picks the operating mode and reports a busy flag. The port can act as clock master, where it makes the serial clock from the system clock by dividing it by four. It can also act as clock slave, where an external clock drives it while an active-low select input is held low.

In full-duplex mode, a CPU write to the data register loads the byte and starts an exchange. In receive-only mode, each CPU read of the data register returns the byte that is already held and starts the next reception. In both modes the port sends the most significant bit first. It changes its output on the falling clock edge and samples its input on the rising edge. It raises a one-cycle completion pulse when the eighth bit is in. While an exchange is in flight, bus accesses to the data or control register are dropped. This keeps the transfer intact.

Top module: `sser_port`

## Requirements
- R1: After reset, both registers read 00h. `busy`, `xfer_irq`, `sclk_oe` and `sdo_oe` are 0, and `sclk_o` is 1.
- R2: The control register is at `bus_addr`=1. Its bit 7 is enable, bit 6 is mode (1 = full duplex, 0 = receive-only) and bit 5 is role (1 = slave). Bit 0 reads back the busy flag and the other bits read 0. With enable=1 and mode=1, a write to the data register (`bus_addr`=0) while idle loads the byte and starts an 8-bit exchange. That byte goes out on `sdo` MSB first, and the eight bits taken from `sdi` (first bit into the MSB) then replace it in the data register.
- R3: With enable=1 and mode=0, a read of the data register while idle returns the byte currently held and starts an 8-bit reception. A write in this mode only loads the register and starts nothing.
- R4: With enable=0, neither a read nor a write of the data register starts a transfer. `busy` stays 0 and `sclk_o` stays high.
- R5: `busy` (the port and control bit 0) is 1 from the cycle after the starting access until the transfer ends. In master role this is exactly 30 system cycles.
- R6: While `busy` is 1, writes and reads of either register are ignored. They do not restart the transfer, alter the data register or change the control register.
- R7: In master role, `sclk_o` idles high and, during a transfer, runs at one quarter of the system clock with 8 falling and 8 rising edges. `sdo` takes a new bit on each falling edge and `sdi` is sampled at each rising edge.
- R8: The cycle after the eighth bit is sampled, `xfer_irq` is 1 for exactly one cycle and `busy` falls in that same cycle.
- R9: In slave role, the transfer advances only on edges of `sclk_i` seen while `ss_n` is low. Edges while `ss_n` is high leave the data register and `busy` unchanged.
- R10: `sclk_oe` is 1 only when enabled in master role. `sdo_oe` is 1 when enabled in master role, or when enabled in slave role with `ss_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle |
| bus_wr | input | 1 | Access is a write |
| bus_rd | input | 1 | Access is a read |
| bus_addr | input | 1 | 0 = data register, 1 = control register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| busy | output | 1 | Transfer in progress |
| xfer_irq | output | 1 | One-cycle transfer-complete pulse |
| sclk_o | output | 1 | Serial clock driven in master role |
| sclk_oe | output | 1 | Output enable for sclk_o |
| sclk_i | input | 1 | Serial clock received in slave role |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| ss_n | input | 1 | Active-low select in slave role |

## Verification
A bit counter that is off by one shows up at the ports right away. It changes the count of serial clock edges and the 30-cycle busy window, and the completed byte comes out rotated. All of this is visible within one transfer. If the gating against bus accesses while busy has a fault, the effect is visible before the current transfer ends: either busy stays high past its 30 cycles or the final byte is corrupted. A slave that reacts to clock edges while deselected leaves a shifted byte in the data register, and a readback right after the transfer shows it. If the one-cycle completion flag sticks, the pulse appears twice in the cycles after busy falls.

// File: rtl/sser_pkg.sv
package sser_pkg;
    localparam int DW      = 8;
    localparam int CTL_EN  = 7;
    localparam int CTL_DUP = 6;
    localparam int CTL_SLV = 5;

    typedef struct packed {
        logic en;
        logic dup;
        logic slv;
    } ctl_t;
endpackage

// File: rtl/sser_mclk.sv
module sser_mclk #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic smp,
    output logic shf
);
    localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    logic [PW-1:0] ph_d, ph_q;

    always_comb begin
        if (!run)                       ph_d = '0;
        else if (ph_q == PW'(DIV - 1))  ph_d = '0;
        else                            ph_d = ph_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign sclk = !run || (ph_q >= PW'(HALF));
    assign smp  = run && (ph_q == PW'(HALF - 1));
    assign shf  = run && (ph_q == PW'(DIV - 1));

    AST_SAMPLE_THEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        smp |=> sclk); // R7
endmodule

// File: rtl/sser_sync.sv
module sser_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sdi,
    input  logic ss_n,
    output logic smp,
    output logic shf,
    output logic sdi_s,
    output logic sel
);
    typedef struct packed {
        logic [STAGES-1:0] ck;
        logic [STAGES-1:0] dt;
        logic [STAGES-1:0] ss;
        logic              prev;
    } sy_t;

    sy_t d, q;
    logic ck_now;

    always_comb begin
        d      = q;
        d.ck   = {q.ck[STAGES-2:0], sclk_i};
        d.dt   = {q.dt[STAGES-2:0], sdi};
        d.ss   = {q.ss[STAGES-2:0], ss_n};
        d.prev = q.ck[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ck   <= '1;
            q.dt   <= '0;
            q.ss   <= '1;
            q.prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ck_now = q.ck[STAGES-1];
    assign sel    = ~q.ss[STAGES-1];
    assign smp    = sel & ck_now & ~q.prev;
    assign shf    = sel & ~ck_now & q.prev;
    assign sdi_s  = q.dt[STAGES-1];
endmodule

// File: rtl/sser_shift.sv
module sser_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [DW-1:0] ld_data,
    input  logic          start,
    input  logic          smp,
    input  logic          shf,
    input  logic          sdi,
    output logic [DW-1:0] data,
    output logic          busy,
    output logic          done
);
    localparam int CW = $clog2(DW);

    typedef struct packed {
        logic [DW-1:0] sr;
        logic [CW-1:0] cnt;
        logic          busy;
        logic          got;
        logic          rx;
        logic          done;
    } sh_t;

    sh_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (ld) d.sr = ld_data;
            if (start) begin
                d.busy = 1'b1;
                d.cnt  = '0;
                d.got  = 1'b0;
            end
        end else if (smp) begin
            if (q.cnt == CW'(DW - 1)) begin
                d.sr   = {q.sr[DW-2:0], sdi};
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.rx  = sdi;
                d.got = 1'b1;
            end
        end else if (shf && q.got) begin
            d.sr  = {q.sr[DW-2:0], q.rx};
            d.cnt = q.cnt + 1'b1;
            d.got = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data = q.sr;
    assign busy = q.busy;
    assign done = q.done;

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (!q.busy && $past(q.busy))); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done); // R8
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !smp && !shf) |=> $stable(q.sr)); // R6
endmodule

// File: rtl/sser_port.sv
module sser_port
    import sser_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int SYNC    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          busy,
    output logic          xfer_irq,
    output logic          sclk_o,
    output logic          sclk_oe,
    input  logic          sclk_i,
    input  logic          sdi,
    output logic          sdo,
    output logic          sdo_oe,
    input  logic          ss_n
);
    ctl_t ctl_d, ctl_q;

    logic          hit_dat, hit_ctl, start, ld;
    logic          m_smp, m_shf, s_smp, s_shf, s_sdi, s_sel;
    logic          smp, shf, bit_in, run;
    logic [DW-1:0] data;

    always_comb begin
        hit_dat = bus_sel && !bus_addr && !busy;
        hit_ctl = bus_sel &&  bus_addr && !busy;
        start   = hit_dat && ctl_q.en && (ctl_q.dup ? bus_wr : bus_rd);
        ld      = hit_dat && bus_wr;
        ctl_d   = ctl_q;
        if (hit_ctl && bus_wr) begin
            ctl_d.en  = bus_wdata[CTL_EN];
            ctl_d.dup = bus_wdata[CTL_DUP];
            ctl_d.slv = bus_wdata[CTL_SLV];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign run    = busy && !ctl_q.slv;
    assign smp    = ctl_q.slv ? s_smp : m_smp;
    assign shf    = ctl_q.slv ? s_shf : m_shf;
    assign bit_in = ctl_q.slv ? s_sdi : sdi;

    sser_mclk #(.DIV(CLK_DIV)) u_mclk (
        .clk(clk), .rst_n(rst_n), .run(run),
        .sclk(sclk_o), .smp(m_smp), .shf(m_shf)
    );

    sser_sync #(.STAGES(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdi(sdi), .ss_n(ss_n),
        .smp(s_smp), .shf(s_shf), .sdi_s(s_sdi), .sel(s_sel)
    );

    sser_shift #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .ld(ld), .ld_data(bus_wdata), .start(start),
        .smp(smp), .shf(shf), .sdi(bit_in),
        .data(data), .busy(busy), .done(xfer_irq)
    );

    assign sdo       = data[DW-1];
    assign sclk_oe   = ctl_q.en && !ctl_q.slv;
    assign sdo_oe    = ctl_q.en && (!ctl_q.slv || !ss_n);
    assign bus_rdata = bus_addr ? {ctl_q.en, ctl_q.dup, ctl_q.slv, {(DW-4){1'b0}}, busy}
                                : data;

    AST_BUSY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ctl_q.en); // R4
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R5
    AST_CTL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctl_q)); // R6
    AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk_o); // R7
    AST_DESELECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_q.slv && !s_sel) |=> $stable(data)); // R9
endmodule

// File: tb/sim_sser_port.sv
module sim_sser_port;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       bus_sel = 0, bus_wr = 0, bus_rd = 0, bus_addr = 0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       busy, xfer_irq, sclk_o, sclk_oe, sdo, sdo_oe;
    logic       sclk_i = 1'b1, sdi = 1'b0, ss_n = 1'b1;
    int         n_chk = 0, n_err = 0, irq_seen = 0;
    bit         finished = 0;

    always #2 clk = ~clk;

    sser_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .xfer_irq(xfer_irq), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
        .sclk_i(sclk_i), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .ss_n(ss_n)
    );

    function automatic logic [7:0] ctl_exp(input bit en, dup, slv, bsy);
        return {en, dup, slv, 4'b0000, bsy};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wcy(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (xfer_irq) irq_seen++;
        end
    endtask

    task automatic bus_wr_t(input logic a, input logic [7:0] v);
        bus_sel = 1; bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = v;
        wcy(1);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_rd_t(input logic a, output logic [7:0] v);
        bus_sel = 1; bus_rd = 1; bus_wr = 0; bus_addr = a;
        #1 v = bus_rdata;
        wcy(1);
        bus_sel = 0; bus_rd = 0;
    endtask

    // master-role exchange; the bench models the remote device
    task automatic m_xfer(input bit dup, input logic [7:0] wv, input logic [7:0] dev, input bit meddle);
        logic [7:0] rx = '0, rv;
        logic prev = 1'b1, cur = 1'b0;
        int falls = 0, rises = 0, busyc = 0, irqc = 0;
        bus_wr_t(1'b1, dup ? 8'hC0 : 8'h80);
        if (dup) begin
            bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = wv;
        end else begin
            bus_wr_t(1'b0, wv);
            bus_sel = 1; bus_rd = 1; bus_addr = 0;
            #1 chk("R3 read returns held byte", bus_rdata, wv);
        end
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_rd = 0;
        for (int c = 0; c < 40; c++) begin
            if (busy) busyc++;
            if (xfer_irq) irqc++;
            if (prev && !sclk_o) begin
                if (falls < 8) sdi = dev[7 - falls];
                falls++;
            end
            if (!sclk_o) cur = sdo;
            if (!prev && sclk_o) begin
                rx = {rx[6:0], cur};
                rises++;
            end
            prev = sclk_o;
            bus_sel = 0; bus_wr = 0; bus_rd = 0;
            if (meddle && c == 10) begin bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = ~wv; end
            if (meddle && c == 11) begin bus_sel = 1; bus_rd = 1; bus_addr = 0; end
            if (meddle && c == 12) begin bus_sel = 1; bus_wr = 1; bus_addr = 1; bus_wdata = 8'h00; end
            @(negedge clk);
        end
        bus_sel = 0; bus_wr = 0; bus_rd = 0;
        chk("R5 busy window", busyc, 30);
        chk("R7 falling edges", falls, 8);
        chk("R7 rising edges", rises, 8);
        chk("R8 completion pulses", irqc, 1);
        chk("R2 bits sent MSB first", rx, wv);
        bus_rd_t(1'b1, rv);
        chk(meddle ? "R6 control unchanged" : "R2 control readback", rv, ctl_exp(1, dup, 0, 0));
        bus_wr_t(1'b1, 8'h00);
        bus_rd_t(1'b0, rv);
        chk(dup ? "R2 received byte" : "R3 received byte", rv, dev);
        if (meddle) chk("R6 no restart", busy, 0);
    endtask

    // slave-role exchange; the bench acts as the clock master
    task automatic s_xfer(input bit dup, input logic [7:0] pre, input logic [7:0] mst);
        logic [7:0] rx = '0, rv;
        bus_wr_t(1'b1, dup ? 8'hE0 : 8'hA0);
        chk("R10 sclk_oe off in slave", sclk_oe, 0);
        if (dup) bus_wr_t(1'b0, pre);
        else begin
            bus_wr_t(1'b0, pre);
            chk("R3 write does not start", busy, 0);
            bus_rd_t(1'b0, rv);
            chk("R3 read returns held byte", rv, pre);
        end
        wcy(2);
        chk("R5 busy after start", busy, 1);
        chk("R10 sdo_oe off when deselected", sdo_oe, 0);
        for (int i = 0; i < 3; i++) begin
            sclk_i = 0; wcy(8); sclk_i = 1; wcy(8);
        end
        bus_rd_t(1'b0, rv);
        chk("R9 edges ignored while deselected", rv, pre);
        chk("R9 still busy", busy, 1);
        ss_n = 0;
        wcy(4);
        chk("R10 sdo_oe on when selected", sdo_oe, 1);
        irq_seen = 0;
        for (int i = 0; i < 8; i++) begin
            sclk_i = 0; sdi = mst[7 - i];
            wcy(8);
            rx = {rx[6:0], sdo};
            sclk_i = 1;
            wcy(8);
        end
        wcy(4);
        ss_n = 1;
        chk("R8 slave completion pulse", irq_seen, 1);
        chk("R9 slave done", busy, 0);
        chk("R9 slave sent byte", rx, pre);
        bus_wr_t(1'b1, 8'h00);
        bus_rd_t(1'b0, rv);
        chk("R9 slave received byte", rv, mst);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        void'($urandom(32'h1D5E));
        wcy(3);
        rst_n = 1;
        wcy(2);
        // R1 reset state
        bus_rd_t(1'b1, rv); chk("R1 control reset", rv, 8'h00);
        bus_rd_t(1'b0, rv); chk("R1 data reset", rv, 8'h00);
        chk("R1 busy", busy, 0);
        chk("R1 irq", xfer_irq, 0);
        chk("R1 sclk idle", sclk_o, 1);
        chk("R1 oe", {sclk_oe, sdo_oe}, 2'b00);
        // R4 disabled: neither write nor read starts
        bus_wr_t(1'b1, 8'h40);
        bus_wr_t(1'b0, 8'h5A);
        wcy(6);
        chk("R4 no start on write", busy, 0);
        chk("R4 clock idle", sclk_o, 1);
        bus_wr_t(1'b1, 8'h00);
        bus_rd_t(1'b0, rv);
        chk("R4 data kept", rv, 8'h5A);
        wcy(4);
        chk("R4 no start on read", busy, 0);
        // R10 master enables
        bus_wr_t(1'b1, 8'hC0);
        chk("R10 master oe", {sclk_oe, sdo_oe}, 2'b11);
        // directed corner bytes
        m_xfer(1, 8'h80, 8'h01, 0);
        m_xfer(1, 8'hFF, 8'h00, 0);
        m_xfer(0, 8'h01, 8'hFE, 0);
        m_xfer(1, 8'hA5, 8'h3C, 1);
        m_xfer(0, 8'h96, 8'h69, 1);
        // constrained random
        for (int k = 0; k < 16; k++) begin
            m_xfer(($urandom % 2) == 1, 8'($urandom), 8'($urandom), ($urandom % 4) == 0);
        end
        s_xfer(0, 8'hC3, 8'h5A);
        s_xfer(1, 8'h81, 8'h7E);
        s_xfer(1, 8'($urandom), 8'($urandom));
        finished = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule